// File: doc/BRIEF.md
# Vector-aware branch condition sequencer

This block evaluates one branch-conditional instruction across a vector of 4-bit condition-register fields. It visits elements in order, one per cycle. Each element is first filtered through a predicate mask. Elements that are tested read one CR field through a request/response port. The per-element test results are folded into a single branch decision, either as an AND over all elements or as an OR. The loop stops at the first element that settles the outcome.

Along the way the unit maintains a working copy of the count register. The decrement rules depend on the predicate bit, on the element result and on the counter-test mode bits. The unit can also cut the vector length at the decision point. When it finishes it reports the branch outcome, the next instruction address and the link value. It also reports write strobes for the link register and the state-link register, and those strobes can depend on whether the branch was taken.

A pipeline front end loads the instruction fields together with the current address, count register, vector length and predicate, and then pulses `start`. It waits for `done` and commits the reported values. No element after the exit point is read from the CR file, and no such element changes the count.

Top module: `vbranch_seq`

## Requirements
- R1: While reset is held and after its release, `done` and `cr_req` are low until a `start` is accepted.
- R2: The tested bit is `cr_rsp_data[bi[1:0]]`. The field index is `bi[8:2]` plus the step number when `cr_vec`=1, wrapping modulo 128, and `bi[8:2]` when `cr_vec`=0. The element passes when `bo[0] | ~(testbit ^ bo[1])` and the counter check `bo[2] | (nz ^ bo[3])` both hold, where nz means the count, before any decrement for this element, is non-zero. While `cr_rsp_valid` is low the unit waits and changes nothing.
- R3: With `all_m`=1 the decision starts at 1 and is ANDed with each element result. With `all_m`=0 it starts at 0 and is ORed. The sequence stops at the first result that differs from `all_m`, and no later CR field is requested.
- R4: A masked element (predicate bit 0) with `sz`=1 is tested against `snz` in place of the CR bit, and it issues no CR request.
- R5: A masked element with `sz`=0 is skipped. It issues no request, does not affect the decision and, apart from R6's exception, leaves the count unchanged.
- R6: A tested element decrements the count when `bo[2]`=0, unless `ctr_test`=1 and (condition pass XOR `cti`)=1. A skipped element decrements the count only when `bo[2]`=0, `ctr_test`=0 and `cti`=1.
- R7: With `mode64`=0 only count bits 31:0 take part in the non-zero check. With `mode64`=1 all 64 bits do.
- R8: With `vlset`=1, an element whose result equals `vsb` ends the sequence. It pulses `vl_we` and sets `vl_out` to the step number plus 1 when `vli`=1, or to the step number when `vli`=0. Otherwise `vl_out` equals the loaded length and `vl_we` is 0.
- R9: With a vector length of 0, no field is requested. The branch is taken when `all_m`=1 and not taken when `all_m`=0.
- R10: With `cr_vec`=0 the sequence ends after the first element actually tested, which is the first one not skipped.
- R11: `lr_we` = `lk` XOR (`lru` AND taken), and `svlr_we` = `sl` XOR (`slu` AND taken).
- R12: The target is `bd` followed by two zero bits, sign-extended. It is absolute when `aa`=1 and added to `cia` when `aa`=0. `nia` is the target when taken and `cia`+8 otherwise, and `lr_value` is `cia`+8.
- R13: `done` is high for exactly one cycle per accepted `start`. The reported results are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin evaluation |
| vl | input | 7 | Vector length, 0 to 64 |
| pred | input | 64 | Predicate mask, bit i for element i |
| bo | input | 4 | Branch options: 0 ignore condition, 1 wanted bit value, 2 ignore count, 3 count-zero sense |
| bi | input | 9 | Field index (8:2) and bit within field (1:0) |
| aa | input | 1 | Absolute target |
| lk | input | 1 | Link request |
| bd | input | 14 | Branch displacement in words |
| cia | input | 64 | Current instruction address |
| ctr_in | input | 64 | Count register on entry |
| mode64 | input | 1 | 64-bit count check |
| cr_vec | input | 1 | CR operand is a vector |
| all_m | input | 1 | AND-fold when 1, OR-fold when 0 |
| snz | input | 1 | Substitute bit for masked elements when sz=1 |
| sz | input | 1 | Masked elements are tested (1) or skipped (0) |
| ctr_test | input | 1 | Counter-test mode |
| cti | input | 1 | Counter-test inversion |
| vlset | input | 1 | Length truncation mode |
| vsb | input | 1 | Result value that triggers truncation |
| vli | input | 1 | Truncated length includes the current element |
| lru | input | 1 | Invert link strobe when taken |
| sl | input | 1 | State-link request |
| slu | input | 1 | Invert state-link strobe when taken |
| cr_req | output | 1 | CR field read request |
| cr_idx | output | 7 | CR field index requested |
| cr_rsp_valid | input | 1 | CR response present this cycle |
| cr_rsp_data | input | 4 | CR field contents |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision |
| nia | output | 64 | Next instruction address |
| lr_value | output | 64 | Link value (cia+8) |
| ctr_out | output | 64 | Updated count register |
| vl_out | output | 7 | Resulting vector length |
| vl_we | output | 1 | Vector length write strobe |
| lr_we | output | 1 | Link register write strobe |
| svlr_we | output | 1 | State-link register write strobe |

## Verification
The hardest case to reach from the ports is an exit in the middle of the vector. It must fall on an element reached after skipped, masked elements, and those skipped elements must still move the count under the inverted skip rule, so the final count, the truncated length and the number of CR reads all show exactly where the sequence stopped. The bench reaches it with directed predicate patterns and field contents that place one failing or passing field after runs of masked elements. It also holds back `cr_rsp_valid` on alternate cycles so that stalls fall on tested elements. Pseudo-random mode and predicate sweeps, checked against a model computed from the requirements, cover the remaining combinations of fold mode, substitution and counter-test options.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    typedef struct packed {
        logic       all_m;
        logic       snz;
        logic       sz;
        logic       ctr_test;
        logic       cti;
        logic       vlset;
        logic       vsb;
        logic       vli;
        logic       lru;
        logic       sl;
        logic       slu;
        logic       lk;
        logic       aa;
        logic       mode64;
        logic       cr_vec;
        logic [3:0] bo;
    } mode_t;

endpackage

// File: rtl/vbr_elem_test.sv
module vbr_elem_test #(
    parameter int XLEN = 64
) (
    input  logic [3:0]      bo,
    input  logic            testbit,
    input  logic [XLEN-1:0] ctr,
    input  logic            mode64,
    input  logic            ctr_test,
    input  logic            cti,
    output logic            el_res,
    output logic            el_dec,
    output logic            skip_dec
);
    logic nz;
    logic cond_ok;
    logic cnt_ok;

    generate
        if (XLEN > 32) begin : g_wide
            assign nz = mode64 ? (|ctr) : (|ctr[31:0]);
        end else begin : g_narrow
            assign nz = |ctr;
        end
    endgenerate

    always_comb begin
        cond_ok  = bo[0] | ~(testbit ^ bo[1]);
        cnt_ok   = bo[2] | (nz ^ bo[3]);
        el_res   = cond_ok & cnt_ok;
        el_dec   = ~bo[2] & ~(ctr_test & (cond_ok ^ cti));
        skip_dec = ~bo[2] & ~ctr_test & cti;
    end

endmodule

// File: rtl/vbr_target.sv
module vbr_target #(
    parameter int XLEN = 64,
    parameter int BDW  = 14
) (
    input  logic [XLEN-1:0] cia,
    input  logic [BDW-1:0]  bd,
    input  logic            aa,
    input  logic            taken,
    output logic [XLEN-1:0] nia,
    output logic [XLEN-1:0] link
);
    localparam int EXT = XLEN - BDW - 2;

    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] tgt;

    always_comb begin
        disp = {{EXT{bd[BDW-1]}}, bd, 2'b00};
        tgt  = aa ? disp : (cia + disp);
        link = cia + XLEN'(8);
        nia  = taken ? tgt : link;
    end

endmodule

// File: rtl/vbranch_seq.sv
module vbranch_seq
    import vbr_pkg::*;
#(
    parameter int VMAX = 64,
    parameter int XLEN = 64,
    parameter int BDW  = 14,
    parameter int NFLD = 128,
    localparam int VLW = $clog2(VMAX + 1),
    localparam int FLW = $clog2(NFLD),
    localparam int BIW = FLW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VLW-1:0]  vl,
    input  logic [VMAX-1:0] pred,
    input  logic [3:0]      bo,
    input  logic [BIW-1:0]  bi,
    input  logic            aa,
    input  logic            lk,
    input  logic [BDW-1:0]  bd,
    input  logic [XLEN-1:0] cia,
    input  logic [XLEN-1:0] ctr_in,
    input  logic            mode64,
    input  logic            cr_vec,
    input  logic            all_m,
    input  logic            snz,
    input  logic            sz,
    input  logic            ctr_test,
    input  logic            cti,
    input  logic            vlset,
    input  logic            vsb,
    input  logic            vli,
    input  logic            lru,
    input  logic            sl,
    input  logic            slu,
    output logic            cr_req,
    output logic [FLW-1:0]  cr_idx,
    input  logic            cr_rsp_valid,
    input  logic [3:0]      cr_rsp_data,
    output logic            done,
    output logic            taken,
    output logic [XLEN-1:0] nia,
    output logic [XLEN-1:0] lr_value,
    output logic [XLEN-1:0] ctr_out,
    output logic [VLW-1:0]  vl_out,
    output logic            vl_we,
    output logic            lr_we,
    output logic            svlr_we
);

    typedef struct packed {
        st_e             st;
        logic [VLW-1:0]  step;
        logic            acc;
        logic [XLEN-1:0] ctr;
        logic [VLW-1:0]  vl;
        logic [VMAX-1:0] pred;
        logic [BIW-1:0]  bi;
        logic [BDW-1:0]  bd;
        logic [XLEN-1:0] cia;
        mode_t           m;
        logic            done;
        logic            taken;
        logic [VLW-1:0]  vl_o;
        logic            vl_we;
        logic            lr_we;
        logic            svlr_we;
    } seq_t;

    seq_t r_q, r_d;

    logic            busy;
    logic            in_range;
    logic            pbit;
    logic            testbit;
    logic [VMAX-1:0] pred_sh;
    logic            el_res;
    logic            el_dec;
    logic            skip_dec;
    logic            fin;
    logic            acc_n;

    // Element position and predicate lookup for the current step
    always_comb begin
        busy     = (r_q.st == ST_RUN);
        in_range = (r_q.step < r_q.vl);
        pred_sh  = r_q.pred >> r_q.step;
        pbit     = pred_sh[0];
        testbit  = pbit ? cr_rsp_data[r_q.bi[1:0]] : r_q.m.snz;
        cr_req   = busy & in_range & pbit;
        cr_idx   = r_q.bi[BIW-1:2] + (r_q.m.cr_vec ? FLW'(r_q.step) : FLW'(0));
    end

    vbr_elem_test #(
        .XLEN(XLEN)
    ) u_elem (
        .bo       (r_q.m.bo),
        .testbit  (testbit),
        .ctr      (r_q.ctr),
        .mode64   (r_q.m.mode64),
        .ctr_test (r_q.m.ctr_test),
        .cti      (r_q.m.cti),
        .el_res   (el_res),
        .el_dec   (el_dec),
        .skip_dec (skip_dec)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        fin      = 1'b0;
        acc_n    = r_q.acc;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_RUN;
                    r_d.step  = '0;
                    r_d.acc   = all_m;
                    r_d.ctr   = ctr_in;
                    r_d.vl    = vl;
                    r_d.vl_o  = vl;
                    r_d.vl_we = 1'b0;
                    r_d.pred  = pred;
                    r_d.bi    = bi;
                    r_d.bd    = bd;
                    r_d.cia   = cia;
                    r_d.m     = '{all_m: all_m, snz: snz, sz: sz,
                                  ctr_test: ctr_test, cti: cti,
                                  vlset: vlset, vsb: vsb, vli: vli,
                                  lru: lru, sl: sl, slu: slu, lk: lk,
                                  aa: aa, mode64: mode64,
                                  cr_vec: cr_vec, bo: bo};
                end
            end
            ST_RUN: begin
                if (!in_range) begin
                    fin = 1'b1;
                end else if (!pbit && !r_q.m.sz) begin
                    // masked and skipped: only the inverted skip rule acts
                    if (skip_dec) begin
                        r_d.ctr = r_q.ctr - XLEN'(1);
                    end
                    r_d.step = r_q.step + 1'b1;
                end else if (!pbit || cr_rsp_valid) begin
                    if (el_dec) begin
                        r_d.ctr = r_q.ctr - XLEN'(1);
                    end
                    acc_n    = r_q.m.all_m ? (r_q.acc & el_res) : (r_q.acc | el_res);
                    r_d.acc  = acc_n;
                    r_d.step = r_q.step + 1'b1;
                    if (r_q.m.vlset && (r_q.m.vsb == el_res)) begin
                        r_d.vl_o  = r_q.m.vli ? (r_q.step + 1'b1) : r_q.step;
                        r_d.vl_we = 1'b1;
                        fin       = 1'b1;
                    end else if (r_q.m.all_m != el_res) begin
                        fin = 1'b1;
                    end else if (!r_q.m.cr_vec) begin
                        fin = 1'b1;
                    end
                end
                if (fin) begin
                    r_d.st      = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.taken   = acc_n;
                    r_d.lr_we   = r_q.m.lk ^ (r_q.m.lru & acc_n);
                    r_d.svlr_we = r_q.m.sl ^ (r_q.m.slu & acc_n);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    vbr_target #(
        .XLEN(XLEN),
        .BDW (BDW)
    ) u_tgt (
        .cia   (r_q.cia),
        .bd    (r_q.bd),
        .aa    (r_q.m.aa),
        .taken (r_q.taken),
        .nia   (nia),
        .link  (lr_value)
    );

    assign done    = r_q.done;
    assign taken   = r_q.taken;
    assign ctr_out = r_q.ctr;
    assign vl_out  = r_q.vl_o;
    assign vl_we   = r_q.vl_we;
    assign lr_we   = r_q.lr_we;
    assign svlr_we = r_q.svlr_we;

endmodule

// File: rtl/vbr_seq_chk.sv
module vbr_seq_chk #(
    parameter int XLEN = 64,
    parameter int VLW  = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            taken,
    input logic            cr_req,
    input logic            vl_we,
    input logic [VLW-1:0]  vl_o,
    input logic [VLW-1:0]  vl_q,
    input logic            all_q,
    input logic [XLEN-1:0] ctr_q,
    input logic [XLEN-1:0] nia,
    input logic [XLEN-1:0] cia_q
);

    // R13: completion is a single-cycle pulse
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: no CR traffic outside an evaluation
    p_idle_noreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cr_req);

    // R6: the count moves by at most one per cycle while running
    p_ctr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((ctr_q == $past(ctr_q)) || (ctr_q == $past(ctr_q) - 1)));

    // R8: a truncated length never exceeds the loaded one
    p_vl_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vl_we) |-> (vl_o <= vl_q));

    // R9: empty vector gives the fold's starting value
    p_vl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (vl_q == '0)) |-> (taken == all_q));

    // R12: not taken falls through to the following prefixed instruction
    p_fallthru_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (nia == cia_q + XLEN'(8)));

endmodule

bind vbranch_seq vbr_seq_chk #(
    .XLEN(XLEN),
    .VLW (VLW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .taken  (taken),
    .cr_req (cr_req),
    .vl_we  (vl_we),
    .vl_o   (vl_out),
    .vl_q   (r_q.vl),
    .all_q  (r_q.m.all_m),
    .ctr_q  (r_q.ctr),
    .nia    (nia),
    .cia_q  (r_q.cia)
);

// File: tb/tb_vbranch_seq.sv
`timescale 1ns/1ps
module tb_vbranch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl;
    logic [63:0] pred;
    logic [3:0]  bo;
    logic [8:0]  bi;
    logic        aa, lk, mode64, cr_vec, all_m, snz, sz, ctr_test, cti;
    logic        vlset, vsb, vli, lru, sl, slu;
    logic [13:0] bd;
    logic [63:0] cia, ctr_in;
    logic        cr_req, cr_rsp_valid;
    logic [6:0]  cr_idx;
    logic [3:0]  cr_rsp_data;
    logic        done, taken, vl_we, lr_we, svlr_we;
    logic [63:0] nia, lr_value, ctr_out;
    logic [6:0]  vl_out;

    logic [3:0]  crmem [128];
    logic        stall_en = 1'b0;
    logic        stall_tog = 1'b0;
    int          nreads = 0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    logic        e_taken, e_vlwe, e_lr, e_svlr;
    logic [63:0] e_nia, e_ctr, e_link;
    logic [6:0]  e_vl;
    int          e_reads;

    always #2 clk = ~clk;

    assign cr_rsp_data  = crmem[cr_idx];
    assign cr_rsp_valid = cr_req & ~(stall_en & stall_tog);

    always @(posedge clk) begin
        stall_tog <= ~stall_tog;
        if (cr_req && cr_rsp_valid) nreads <= nreads + 1;
    end

    vbranch_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred(pred),
        .bo(bo), .bi(bi), .aa(aa), .lk(lk), .bd(bd), .cia(cia),
        .ctr_in(ctr_in), .mode64(mode64), .cr_vec(cr_vec), .all_m(all_m),
        .snz(snz), .sz(sz), .ctr_test(ctr_test), .cti(cti), .vlset(vlset),
        .vsb(vsb), .vli(vli), .lru(lru), .sl(sl), .slu(slu),
        .cr_req(cr_req), .cr_idx(cr_idx), .cr_rsp_valid(cr_rsp_valid),
        .cr_rsp_data(cr_rsp_data), .done(done), .taken(taken), .nia(nia),
        .lr_value(lr_value), .ctr_out(ctr_out), .vl_out(vl_out),
        .vl_we(vl_we), .lr_we(lr_we), .svlr_we(svlr_we)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        vl = 7'd4; pred = '1; bo = 4'b0100; bi = {7'd8, 2'd0};
        aa = 0; lk = 0; bd = 14'd16; cia = 64'h1000; ctr_in = 64'd10;
        mode64 = 1; cr_vec = 1; all_m = 0; snz = 0; sz = 0; ctr_test = 0;
        cti = 0; vlset = 0; vsb = 0; vli = 0; lru = 0; sl = 0; slu = 0;
        stall_en = 0;
        for (int i = 0; i < 128; i++) crmem[i] = 4'h0;
    endtask

    // Expected results computed from the requirements
    task automatic model();
        logic acc, p, tb, nz, cok, eok, r;
        logic [63:0] c, off, tgt;
        acc = all_m; c = ctr_in; e_vl = vl; e_vlwe = 0; e_reads = 0;
        for (int s = 0; s < int'(vl); s++) begin
            p = pred[s];
            if (!p && !sz) begin
                if (!bo[2] && !ctr_test && cti) c = c - 1;
                continue;
            end
            if (p) begin
                tb = crmem[7'(int'(bi[8:2]) + (cr_vec ? s : 0))][bi[1:0]];
                e_reads++;
            end else begin
                tb = snz;
            end
            nz  = mode64 ? (c != 0) : (c[31:0] != 0);
            cok = bo[2] | (nz ^ bo[3]);
            eok = bo[0] | ~(tb ^ bo[1]);
            r   = eok & cok;
            if (!bo[2] && !(ctr_test && (eok ^ cti))) c = c - 1;
            acc = all_m ? (acc & r) : (acc | r);
            if (vlset && (vsb == r)) begin
                e_vl = vli ? 7'(s + 1) : 7'(s);
                e_vlwe = 1;
                break;
            end
            if (all_m != r) break;
            if (!cr_vec) break;
        end
        e_taken = acc; e_ctr = c;
        e_lr = lk ^ (lru & acc);
        e_svlr = sl ^ (slu & acc);
        off = {{48{bd[13]}}, bd, 2'b00};
        tgt = aa ? off : cia + off;
        e_link = cia + 64'd8;
        e_nia = acc ? tgt : e_link;
    endtask

    task automatic run_check(input string tag);
        int n, base;
        model();
        @(negedge clk);
        base = nreads;
        start = 1;
        @(negedge clk);
        start = 0;
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL %s R13 done act=0 exp=1", tag);
            return;
        end
        chk({tag, " R3 taken"}, 64'(taken), 64'(e_taken));
        chk({tag, " R12 nia"}, nia, e_nia);
        chk({tag, " R12 link"}, lr_value, e_link);
        chk({tag, " R6 ctr"}, ctr_out, e_ctr);
        chk({tag, " R8 vl_we"}, 64'(vl_we), 64'(e_vlwe));
        chk({tag, " R8 vl"}, 64'(vl_out), 64'(e_vl));
        chk({tag, " R11 lr_we"}, 64'(lr_we), 64'(e_lr));
        chk({tag, " R11 svlr_we"}, 64'(svlr_we), 64'(e_svlr));
        @(negedge clk);
        chk({tag, " R3 reads"}, 64'(nreads - base), 64'(e_reads));
        chk({tag, " R13 done pulse"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 req in reset", 64'(cr_req), 64'd0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 done after reset", 64'(done), 64'd0);
        chk("R1 req after reset", 64'(cr_req), 64'd0);
    endtask

    task automatic t_bitsel();
        defaults(); vl = 1; bo = 4'b0110; crmem[8] = 4'b0100;
        bi = {7'd8, 2'd2}; run_check("R2 bit2 set");
        chk("R2 taken bit2", 64'(taken), 64'd1);
        bi = {7'd8, 2'd1}; run_check("R2 bit1 clear");
        chk("R2 not taken bit1", 64'(taken), 64'd0);
        bo = 4'b0101; run_check("R2 ignore cond");
        chk("R2 taken ignore", 64'(taken), 64'd1);
    endtask

    task automatic t_any_all();
        defaults(); vl = 8; bo = 4'b0110; crmem[11] = 4'h1;
        run_check("R3 any first success");
        chk("R3 any reads stop", 64'(e_reads), 64'd4);
        defaults(); vl = 8; all_m = 1; bo = 4'b0110;
        for (int i = 8; i < 16; i++) crmem[i] = 4'h1;
        crmem[13] = 4'h0;
        run_check("R3 all first fail");
        chk("R3 all not taken", 64'(taken), 64'd0);
        crmem[13] = 4'h1;
        run_check("R3 all pass");
        chk("R3 all taken", 64'(taken), 64'd1);
    endtask

    task automatic t_wrap();
        defaults(); vl = 4; bo = 4'b0110; bi = {7'd126, 2'd0}; crmem[0] = 4'h1;
        run_check("R2 index wrap");
        chk("R2 wrap taken", 64'(taken), 64'd1);
    endtask

    task automatic t_pred();
        defaults(); vl = 8; all_m = 1; bo = 4'b0010; pred = 64'b1010_0101; sz = 1;
        for (int i = 0; i < 128; i++) crmem[i] = 4'h1;
        snz = 1; run_check("R4 snz one");
        snz = 0; run_check("R4 snz zero");
        sz = 0; run_check("R5 skip");
    endtask

    task automatic t_ctr();
        defaults(); vl = 8; all_m = 1; bo = 4'b0010; pred = 64'b0110_1101;
        for (int i = 0; i < 128; i++) crmem[i] = 4'h1;
        ctr_in = 64'd40;
        cti = 1; run_check("R6 skip decrement");
        chk("R6 ctr count", ctr_out, 64'd32);
        ctr_test = 1; cti = 0; run_check("R6 dec on pass");
        ctr_test = 1; cti = 1; run_check("R6 dec on fail");
        all_m = 0; crmem[8] = 4'h0; crmem[10] = 4'h0; crmem[11] = 4'h0;
        ctr_test = 1; cti = 1; bo = 4'b0011; run_check("R6 any fail dec");
    endtask

    task automatic t_mode32();
        defaults(); vl = 1; bo = 4'b1001; ctr_in = 64'h1_0000_0000;
        mode64 = 0; run_check("R7 low zero");
        chk("R7 taken 32", 64'(taken), 64'd1);
        mode64 = 1; run_check("R7 full nonzero");
        chk("R7 not taken 64", 64'(taken), 64'd0);
    endtask

    task automatic t_vlset();
        defaults(); vl = 6; all_m = 1; bo = 4'b0110; pred = 64'b110010;
        crmem[9] = 4'h1; crmem[12] = 4'h0; crmem[13] = 4'h1;
        vlset = 1; vsb = 0; vli = 0; run_check("R8 exclusive");
        chk("R8 vl excl", 64'(vl_out), 64'd4);
        vli = 1; run_check("R8 inclusive");
        chk("R8 vl incl", 64'(vl_out), 64'd5);
        all_m = 0; vsb = 1; vli = 0; crmem[9] = 4'h0; crmem[12] = 4'h1;
        run_check("R8 on success");
        defaults(); vlset = 1; vsb = 0; all_m = 1; bo = 4'b0101;
        run_check("R8 no trigger");
    endtask

    task automatic t_vl0();
        defaults(); vl = 0; all_m = 1; run_check("R9 all");
        chk("R9 all taken", 64'(taken), 64'd1);
        all_m = 0; run_check("R9 any");
        chk("R9 any not taken", 64'(taken), 64'd0);
    endtask

    task automatic t_scalar();
        defaults(); vl = 6; cr_vec = 0; all_m = 1; bo = 4'b0110;
        pred = 64'b1100; crmem[8] = 4'h1; run_check("R10 scalar");
        chk("R10 one read", 64'(e_reads), 64'd1);
        chk("R10 taken", 64'(taken), 64'd1);
    endtask

    task automatic t_link();
        defaults(); vl = 1; bo = 4'b0101;
        for (int k = 0; k < 16; k++) begin
            lk = k[0]; lru = k[1]; sl = k[2]; slu = k[3];
            run_check("R11 combo taken");
        end
        bo = 4'b0110; lk = 1; lru = 1; sl = 0; slu = 1;
        run_check("R11 not taken");
    endtask

    task automatic t_target();
        defaults(); vl = 1; bo = 4'b0101; cia = 64'h2000;
        bd = 14'h3FF0; aa = 0; run_check("R12 relative back");
        chk("R12 rel nia", nia, 64'h1FC0);
        aa = 1; bd = 14'h0100; run_check("R12 absolute");
        chk("R12 abs nia", nia, 64'h400);
    endtask

    task automatic t_stall();
        defaults(); vl = 6; bo = 4'b0010; stall_en = 1;
        run_check("R2 stall");
        all_m = 1; for (int i = 0; i < 128; i++) crmem[i] = 4'h1;
        ctr_test = 1; run_check("R2 stall all");
        stall_en = 0;
    endtask

    task automatic t_sweep();
        for (int it = 0; it < 60; it++) begin
            defaults();
            for (int i = 0; i < 128; i++) crmem[i] = 4'($urandom);
            vl = 7'($urandom_range(0, 64));
            pred = {$urandom, $urandom};
            bo = 4'($urandom); bi = 9'($urandom);
            {aa, lk, mode64, cr_vec, all_m, snz, sz, ctr_test} = 8'($urandom);
            {cti, vlset, vsb, vli, lru, sl, slu} = 7'($urandom);
            bd = 14'($urandom); cia = {$urandom, $urandom};
            ctr_in = ($urandom_range(0, 3) == 0) ? 64'(it % 3) : {$urandom, $urandom};
            stall_en = it[0];
            run_check("R3 sweep");
        end
    endtask

    initial begin
        defaults();
        t_reset();
        t_bitsel();
        t_any_all();
        t_wrap();
        t_pred();
        t_ctr();
        t_mode32();
        t_vlset();
        t_vl0();
        t_scalar();
        t_link();
        t_target();
        t_stall();
        t_sweep();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R13 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule